// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache Controller

This block sits between a processor load/store port and a slower memory port and keeps a direct-mapped copy of recently read data. It holds 8 KiB in 32-byte lines, 256 lines in all. Each line has a tag and a valid flag. A load that finds its line returns the 8-byte word with a fixed short latency. A load that misses holds the processor off, asks memory for the whole line, and takes it in two 16-byte beats. It then installs the line and returns the word that was asked for.

Stores are write-through with no allocation on a miss. A store that finds its line merges the enabled bytes into the cached word. Every store, hit or miss, is handed to an external write buffer through a push/ready handshake, and the processor is held off until the buffer takes it. A one-cycle invalidate input drops every line at once.

Top module: `wtc_dcache`

## Requirements
- R1: A 34-bit byte address splits into a byte offset in bits 4:0, a line index in bits 12:5 and a tag in bits 33:13. Within the offset, bits 4:3 select the 8-byte word. Two addresses with the same index and different tags compete for one line, so reading one evicts the other.
- R2: A load hits only when the indexed line is valid and its stored tag equals the address tag. After reset no line is valid, so the first load of any address misses.
- R3: A load hit raises `cpu_ack` for exactly one cycle, two cycles after the cycle in which the request was accepted, with the word on `cpu_rdata`. A hit issues no memory request.
- R4: A load miss raises `mem_req` for one cycle with a line-aligned `mem_addr` (bits 4:0 zero). It then takes two beats on `mem_beat_data`: beat 0 holds line bytes 0–15 and beat 1 holds bytes 16–31, with bits 63:0 of a beat being the lower-addressed word. After the second beat the requested word is acknowledged, and later loads of that line hit.
- R5: A store hit changes only the bytes whose `cpu_be` bit is set. Bit i selects data bits 8i+7:8i of the word at address bits 4:3.
- R6: Every store produces exactly one write-buffer transfer carrying its unchanged address, data and byte enables, in issue order.
- R7: A store miss leaves the cache untouched. It starts no line fill, and a later load of that address still misses.
- R8: While `wb_push` is high and `wb_ready` is low, `cpu_busy` stays high and `wb_addr`, `wb_data` and `wb_be` hold steady until the transfer completes.
- R9: A one-cycle `inv_all` pulse clears every valid flag, so the next load of any previously cached line misses.
- R10: During and straight after reset, `cpu_busy`, `cpu_ack`, `mem_req` and `wb_push` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Pulse that clears every valid flag |
| cpu_valid | input | 1 | Request present; taken when `cpu_busy` is low |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 34 | Byte address of the request |
| cpu_wdata | input | 64 | Store data |
| cpu_be | input | 8 | Store byte enables |
| cpu_busy | output | 1 | Controller is processing a request |
| cpu_ack | output | 1 | One-cycle load-data acknowledge |
| cpu_rdata | output | 64 | Load data, valid with `cpu_ack` |
| mem_req | output | 1 | One-cycle line-fill request |
| mem_addr | output | 34 | Line-aligned fill address |
| mem_beat_valid | input | 1 | A fill beat is present |
| mem_beat_data | input | 128 | Fill beat data |
| wb_push | output | 1 | Store offered to the write buffer |
| wb_addr | output | 34 | Store address |
| wb_data | output | 64 | Store data |
| wb_be | output | 8 | Store byte enables |
| wb_ready | input | 1 | Write buffer can accept the store |

## Verification
The assertions assume a well-behaved environment. A request is offered only while `cpu_busy` is low. Fill beats arrive only after a fill request, and exactly two arrive per request. `inv_all` is pulsed only while the controller is idle. The bench meets these assumptions in three ways. Its driver waits for an idle cycle before each request. Its memory model answers each `mem_req` with exactly two beats, five cycles apart. It raises the invalidate only between requests, while it holds `wb_ready` low for a stretch to provoke the back-pressure stall.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2,
    ST_PUSH   = 2'd3
  } wtc_state_e;

  // Width of a select field for v choices, never below one bit.
  function automatic int log2c(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/wtc_data_bank.sv
// One word-wide bank of the data array with byte-lane write enables.
module wtc_data_bank #(
  parameter int WORD_BYTES = 8,
  parameter int DEPTH      = 512,
  parameter int AW         = 9
) (
  input  logic                    clk,
  input  logic [WORD_BYTES-1:0]   we,
  input  logic [AW-1:0]           waddr,
  input  logic [WORD_BYTES*8-1:0] wdata,
  input  logic                    re,
  input  logic [AW-1:0]           raddr,
  output logic [WORD_BYTES*8-1:0] rdata
);

  logic [WORD_BYTES*8-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (we[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
    end
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/wtc_tag_store.sv
// Tag RAM plus valid flags kept in flops so one pulse can clear them all.
module wtc_tag_store #(
  parameter int LINES = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv_all,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid
);

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_r;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || inv_all) valid_r <= '0;
    else if (wr_en)     valid_r[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_valid <= 1'b0;
    else if (rd_en) rd_valid <= valid_r[rd_idx] & ~inv_all;
  end

  AST_INVALIDATE_ALL: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_r == '0)); // R9

endmodule

// File: rtl/wtc_dcache.sv
module wtc_dcache
  import wtc_pkg::*;
#(
  parameter int ADDR_W     = 34,
  parameter int LINE_BYTES = 32,
  parameter int LINES      = 256,
  parameter int WORD_BYTES = 8,
  parameter int BEAT_BYTES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inv_all,
  input  logic                      cpu_valid,
  input  logic                      cpu_write,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [WORD_BYTES*8-1:0]   cpu_wdata,
  input  logic [WORD_BYTES-1:0]     cpu_be,
  output logic                      cpu_busy,
  output logic                      cpu_ack,
  output logic [WORD_BYTES*8-1:0]   cpu_rdata,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_beat_valid,
  input  logic [BEAT_BYTES*8-1:0]   mem_beat_data,
  output logic                      wb_push,
  output logic [ADDR_W-1:0]         wb_addr,
  output logic [WORD_BYTES*8-1:0]   wb_data,
  output logic [WORD_BYTES-1:0]     wb_be,
  input  logic                      wb_ready
);

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int WORD_W  = WORD_BYTES * 8;
  localparam int BYTE_W  = $clog2(WORD_BYTES);
  localparam int BANKS   = BEAT_BYTES / WORD_BYTES;
  localparam int BANK_W  = log2c(BANKS);
  localparam int BEATS   = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_W  = log2c(BEATS);
  localparam int BANK_AW = IDX_W + BEAT_W;
  localparam int BANK_LO = BYTE_W;
  localparam int BEAT_LO = BYTE_W + BANK_W;

  // Request registers
  wtc_state_e          state_q;
  logic                req_write_q;
  logic [ADDR_W-1:0]   req_addr_q;
  logic [WORD_W-1:0]   req_wdata_q;
  logic [WORD_BYTES-1:0] req_be_q;
  logic [BEAT_W-1:0]   beat_q;
  logic                ack_q;
  logic [WORD_W-1:0]   rdata_q;
  logic                mem_req_q;

  // Address fields
  logic                accept;
  logic [IDX_W-1:0]    cpu_idx;
  logic [BEAT_W-1:0]   cpu_beat;
  logic [IDX_W-1:0]    req_idx;
  logic [TAG_W-1:0]    req_tag;
  logic [BEAT_W-1:0]   req_beat;
  logic [BANK_W-1:0]   req_bank;

  assign accept   = (state_q == ST_IDLE) && cpu_valid;
  assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
  assign cpu_beat = cpu_addr[BEAT_LO +: BEAT_W];
  assign req_idx  = req_addr_q[OFF_W +: IDX_W];
  assign req_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
  assign req_beat = req_addr_q[BEAT_LO +: BEAT_W];
  assign req_bank = req_addr_q[BANK_LO +: BANK_W];

  // Tag lookup
  logic [TAG_W-1:0] look_tag;
  logic             look_valid;
  logic             hit;
  logic             lookup;
  logic             fill_beat;
  logic             last_beat;
  logic             tag_we;

  assign lookup    = (state_q == ST_LOOKUP);
  assign fill_beat = (state_q == ST_FILL) && mem_beat_valid;
  assign last_beat = (beat_q == BEAT_W'(BEATS - 1));
  assign tag_we    = fill_beat && last_beat;
  assign hit       = look_valid && (look_tag == req_tag);

  wtc_tag_store #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst      (rst),
    .inv_all  (inv_all),
    .rd_en    (accept),
    .rd_idx   (cpu_idx),
    .wr_en    (tag_we),
    .wr_idx   (req_idx),
    .wr_tag   (req_tag),
    .rd_tag   (look_tag),
    .rd_valid (look_valid)
  );

  // Data array: one bank per word of a fill beat
  logic [WORD_BYTES-1:0] bank_we    [BANKS];
  logic [WORD_W-1:0]     bank_wdata [BANKS];
  logic [WORD_W-1:0]     bank_rdata [BANKS];
  logic [BANK_AW-1:0]    bank_waddr;
  logic [WORD_W-1:0]     look_word;

  always_comb begin
    bank_waddr = {req_idx, req_beat};
    for (int k = 0; k < BANKS; k++) begin
      bank_we[k]    = '0;
      bank_wdata[k] = req_wdata_q;
    end
    if (fill_beat) begin
      bank_waddr = {req_idx, beat_q};
      for (int k = 0; k < BANKS; k++) begin
        bank_we[k]    = '1;
        bank_wdata[k] = mem_beat_data[k*WORD_W +: WORD_W];
      end
    end else if (lookup && req_write_q && hit) begin
      for (int k = 0; k < BANKS; k++) begin
        if (BANK_W'(k) == req_bank) bank_we[k] = req_be_q;
      end
    end
  end

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    wtc_data_bank #(
      .WORD_BYTES (WORD_BYTES),
      .DEPTH      (LINES * BEATS),
      .AW         (BANK_AW)
    ) u_bank (
      .clk   (clk),
      .we    (bank_we[g]),
      .waddr (bank_waddr),
      .wdata (bank_wdata[g]),
      .re    (accept),
      .raddr ({cpu_idx, cpu_beat}),
      .rdata (bank_rdata[g])
    );
  end

  assign look_word = bank_rdata[req_bank];

  // Control sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_write_q <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      req_be_q    <= '0;
      beat_q      <= '0;
      ack_q       <= 1'b0;
      rdata_q     <= '0;
      mem_req_q   <= 1'b0;
    end else begin
      ack_q     <= 1'b0;
      mem_req_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cpu_valid) begin
            req_write_q <= cpu_write;
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
            req_be_q    <= cpu_be;
            state_q     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (req_write_q) begin
            state_q <= ST_PUSH;
          end else if (hit) begin
            ack_q   <= 1'b1;
            rdata_q <= look_word;
            state_q <= ST_IDLE;
          end else begin
            mem_req_q <= 1'b1;
            beat_q    <= '0;
            state_q   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_beat_valid) begin
            if (beat_q == req_beat)
              rdata_q <= mem_beat_data[int'(req_bank)*WORD_W +: WORD_W];
            if (last_beat) begin
              ack_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
            end
          end
        end
        ST_PUSH: begin
          if (wb_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_busy  = (state_q != ST_IDLE);
  assign cpu_ack   = ack_q;
  assign cpu_rdata = rdata_q;
  assign mem_req   = mem_req_q;
  assign mem_addr  = {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign wb_push   = (state_q == ST_PUSH);
  assign wb_addr   = req_addr_q;
  assign wb_data   = req_wdata_q;
  assign wb_be     = req_be_q;

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack); // R3

  AST_FILL_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R4

  AST_STORE_MISS_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (lookup && req_write_q) |=> !mem_req); // R7

  AST_PUSH_HELD: assert property (@(posedge clk) disable iff (rst)
    (wb_push && !wb_ready) |=> (wb_push && cpu_busy && $stable(wb_addr)
                                && $stable(wb_data) && $stable(wb_be))); // R8

endmodule

// File: tb/wtc_dcache_test.sv
`timescale 1ns/1ps
module wtc_dcache_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inv_all = 1'b0;
  logic         cpu_valid = 1'b0;
  logic         cpu_write = 1'b0;
  logic [33:0]  cpu_addr = '0;
  logic [63:0]  cpu_wdata = '0;
  logic [7:0]   cpu_be = '0;
  logic         cpu_busy, cpu_ack;
  logic [63:0]  cpu_rdata;
  logic         mem_req;
  logic [33:0]  mem_addr;
  logic         mem_beat_valid = 1'b0;
  logic [127:0] mem_beat_data = '0;
  logic         wb_push;
  logic [33:0]  wb_addr;
  logic [63:0]  wb_data;
  logic [7:0]   wb_be;
  logic         wb_ready = 1'b1;

  always #4 clk = ~clk;

  wtc_dcache uut (
    .clk(clk), .rst(rst), .inv_all(inv_all),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_busy(cpu_busy), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
    .wb_push(wb_push), .wb_addr(wb_addr), .wb_data(wb_data), .wb_be(wb_be),
    .wb_ready(wb_ready)
  );

  int total = 0;
  int bad = 0;
  int fill_count = 0;
  bit done = 0;

  logic [63:0]  exp_rd_q [$];
  logic [105:0] exp_wb_q [$];
  logic [63:0]  mem_ovr [logic [33:0]];
  bit           m_valid [256];
  logic [20:0]  m_tag [256];
  logic [63:0]  m_data [256][4];

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [33:0] a);
    return {a[31:0] ^ 32'hC3A5_961E, ~a[33:2]};
  endfunction

  function automatic logic [63:0] mem_word(input logic [33:0] a);
    if (mem_ovr.exists(a)) return mem_ovr[a];
    return pat(a);
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw,
                                        input logic [7:0] be);
    logic [63:0] r = old;
    for (int b = 0; b < 8; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  // Memory model: two 16-byte beats, five cycles apart (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req) begin
        logic [33:0] la;
        la = mem_addr;
        fill_count++;
        chk("R4 fill address aligned", {123'd0, mem_addr[4:0]}, 128'd0);
        for (int k = 0; k < 2; k++) begin
          repeat (4) @(negedge clk);
          mem_beat_valid = 1'b1;
          mem_beat_data  = {mem_word(la + 34'(k*16 + 8)), mem_word(la + 34'(k*16))};
          @(negedge clk);
          mem_beat_valid = 1'b0;
        end
      end
    end
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (cpu_ack) begin
          if (exp_rd_q.size() == 0) chk("R3 unexpected acknowledge", 128'd1, 128'd0);
          else begin
            logic [63:0] e;
            e = exp_rd_q.pop_front();
            chk("R3/R4 load data", {64'd0, cpu_rdata}, {64'd0, e});
          end
        end
        if (wb_push && wb_ready) begin
          if (exp_wb_q.size() == 0) chk("R6 unexpected store transfer", 128'd1, 128'd0);
          else begin
            logic [105:0] e;
            e = exp_wb_q.pop_front();
            chk("R6 store transfer", {22'd0, wb_addr, wb_data, wb_be}, {22'd0, e});
          end
        end
      end
    end
  end

  task automatic model_read(input logic [33:0] a, output bit hit, output logic [63:0] d);
    logic [7:0] idx = a[12:5];
    hit = m_valid[idx] && (m_tag[idx] == a[33:13]);
    if (!hit) begin
      for (int j = 0; j < 4; j++) m_data[idx][j] = mem_word({a[33:5], 5'd0} + 34'(j*8));
      m_valid[idx] = 1'b1;
      m_tag[idx]   = a[33:13];
    end
    d = m_data[idx][a[4:3]];
  endtask

  task automatic issue(input bit wr, input logic [33:0] a, input logic [63:0] d,
                       input logic [7:0] be);
    while (cpu_busy) begin @(posedge clk); #1; end
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d; cpu_be = be;
    @(posedge clk); #1;
    cpu_valid = 1'b0; cpu_write = 1'b0;
  endtask

  task automatic do_read(input logic [33:0] a, input string req);
    bit hit;
    logic [63:0] d;
    int n, fc;
    model_read(a, hit, d);
    exp_rd_q.push_back(d);
    fc = fill_count;
    issue(1'b0, a, 64'd0, 8'd0);
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_ack && n < 100);
    @(negedge clk);
    if (hit) begin
      chk({req, " hit latency"}, 128'(n), 128'd2);
      chk({req, " hit issues no fill"}, 128'(fill_count - fc), 128'd0);
    end else begin
      chk({req, " miss fills once"}, 128'(fill_count - fc), 128'd1);
    end
    @(posedge clk); #1;
  endtask

  task automatic do_write(input logic [33:0] a, input logic [63:0] d, input logic [7:0] be,
                          input string req);
    logic [7:0] idx = a[12:5];
    logic [33:0] wa = {a[33:3], 3'd0};
    int fc;
    exp_wb_q.push_back({a, d, be});
    if (m_valid[idx] && m_tag[idx] == a[33:13])
      m_data[idx][a[4:3]] = merge(m_data[idx][a[4:3]], d, be);
    mem_ovr[wa] = merge(mem_word(wa), d, be);
    fc = fill_count;
    issue(1'b1, a, d, be);
    while (cpu_busy) begin @(posedge clk); #1; end
    chk({req, " store starts no fill"}, 128'(fill_count - fc), 128'd0);
  endtask

  initial begin
    logic [33:0] a_base, b_addr, c_addr;
    logic [31:0] lfsr;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    chk("R10 reset busy", 128'(cpu_busy), 128'd0);
    chk("R10 reset ack", 128'(cpu_ack), 128'd0);
    chk("R10 reset fill request", 128'(mem_req), 128'd0);
    chk("R10 reset push", 128'(wb_push), 128'd0);

    a_base = 34'h1_2345_6780;
    do_read(a_base, "R2");
    do_read(a_base + 34'd8, "R3");
    do_read(a_base + 34'd24, "R4");
    do_read(a_base + 34'd16, "R4");

    do_write(a_base + 34'd16, 64'hDEAD_BEEF_0BAD_F00D, 8'h0F, "R6");
    do_read(a_base + 34'd16, "R5");
    do_write(a_base + 34'd16, 64'h1122_3344_5566_7788, 8'b1010_0101, "R5");
    do_read(a_base + 34'd16, "R5");

    b_addr = 34'h2_0000_1040;
    do_write(b_addr, 64'hCAFE_0000_1234_5678, 8'hFF, "R7");
    do_read(b_addr, "R7");

    c_addr = a_base ^ (34'd1 << 13);
    do_read(c_addr, "R1");
    do_read(a_base + 34'd16, "R1");

    // Back-pressure from the write buffer
    wb_ready = 1'b0;
    exp_wb_q.push_back({a_base, 64'h0F0F_F0F0_5555_AAAA, 8'hFF});
    m_data[a_base[12:5]][a_base[4:3]] = 64'h0F0F_F0F0_5555_AAAA;
    mem_ovr[a_base] = 64'h0F0F_F0F0_5555_AAAA;
    issue(1'b1, a_base, 64'h0F0F_F0F0_5555_AAAA, 8'hFF);
    repeat (6) @(posedge clk);
    #1;
    chk("R8 busy while buffer full", 128'(cpu_busy), 128'd1);
    chk("R8 push held", 128'(wb_push), 128'd1);
    chk("R8 no transfer yet", 128'(exp_wb_q.size()), 128'd1);
    wb_ready = 1'b1;
    @(posedge clk); #1;
    chk("R8 transfer after ready", 128'(exp_wb_q.size()), 128'd0);
    chk("R8 released", 128'(cpu_busy), 128'd0);
    do_read(a_base, "R5");

    // Invalidate all
    inv_all = 1'b1;
    @(posedge clk); #1;
    inv_all = 1'b0;
    for (int i = 0; i < 256; i++) m_valid[i] = 1'b0;
    do_read(a_base, "R9");
    do_read(c_addr, "R9");

    // Mixed traffic over a small conflict set
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 60; i++) begin
      logic [33:0] ra;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = {(lfsr[1] ? 21'h0_00AB : 21'h1_0155), 6'd0, lfsr[5:4], lfsr[7:6], 3'd0};
      if (lfsr[8]) do_write(ra, {lfsr, ~lfsr}, lfsr[16:9] | 8'h01, "R6");
      else         do_read(ra, "R2");
    end

    repeat (4) @(posedge clk);
    #1;
    chk("R6 all stores delivered", 128'(exp_wb_q.size()), 128'd0);
    chk("R3 all loads acknowledged", 128'(exp_rd_q.size()), 128'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule